// File: doc/BRIEF.md
# GPIO Output Bank with Change Notification

This block keeps the output data and output-enable registers of a general-purpose output port. Software reaches them through a byte-wide register port, one lane per access. Each register is 24 bits wide, split into three 8-bit lanes. The block drives 16 output lines. Each line carries the AND of its data bit and its enable bit.

After every write to a data or enable lane, the block works out the new driven vector and compares it with the vector it last published. When any line differs, it pulses a one-cycle strobe together with a mask of the toggled lines. The new vector then becomes the published one. Writes that leave every driven line unchanged produce no strobe.

Notification is handled by a two-state machine. `ST_QUIET` is the resting state. `ST_NOTIFY` is held for exactly one cycle after each write that changed the driven level. The transitions are:
- QUIET→NOTIFY: a write that changes the level.
- NOTIFY→NOTIFY: a back-to-back write that changes the level again.
- NOTIFY→QUIET: any cycle without such a write.
- QUIET→QUIET: idle cycles, or writes that change no line.

Top module: `gpio_out_bank`

## Requirements
- R1: After reset, all data and enable bits, the driven lines and the published level are zero, and `chg_valid` is low.
- R2: Data lane i sits at byte address 0x78+i (i = 0..2) and holds bits [8i+7:8i]. A write changes only that lane, and a read of the address returns the stored lane value combinationally.
- R3: Enable lane i sits at byte address 0x7C+i with the same bit mapping and the same write and read behaviour as R2.
- R4: `gpio_out[k]` equals data bit k AND enable bit k for k = 0..15, starting from the clock edge that stores the write.
- R5: When a write changes the driven level, `chg_valid` is high for exactly the next cycle. In that cycle `chg_mask` holds the previous published level XOR the new level.
- R6: A data or enable write that leaves all 16 driven lines unchanged produces no strobe.
- R7: Bits 16..23 (lane 2 of both registers) are stored and read back, but affect neither `gpio_out` nor the change mask.
- R8: Writes to any other address change no register and no output. Reads of any other address return 0.
- R9: Writes on consecutive cycles that each change the level produce strobes on consecutive cycles, each carrying its own mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Byte write strobe |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| gpio_out | output | 16 | Driven output lines |
| chg_mask | output | 16 | Lines that toggled in the last update |
| chg_valid | output | 1 | One-cycle change strobe |

## Verification
The bench builds the block with its default parameters: 16 lines, three 8-bit lanes, and data and enable bases at 0x78 and 0x7C. With these values, lane 2 holds eight stored-only bits above the driven lines, so the rule that the upper bits are ignored can be tested at the ports. The bench also exercises the gaps at 0x7B and 0x7F and back-to-back lane writes. A queue-based scoreboard predicts every strobe and its mask from a model of the two registers.

// File: rtl/gpob_pkg.sv
package gpob_pkg;
    typedef enum logic [0:0] {
        ST_QUIET  = 1'b0,
        ST_NOTIFY = 1'b1
    } notify_state_t;
endpackage

// File: rtl/gpob_lanes.sv
module gpob_lanes #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8,
    parameter int LANES  = 3,
    parameter logic [ADDR_W-1:0] BASE = 8'h78,
    localparam int W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [W-1:0]      q,
    output logic [W-1:0]      q_next,
    output logic              wr_hit,
    output logic [LANE_W-1:0] rdata
);
    logic [LANES-1:0] sel;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign sel[i] = (addr == BASE + ADDR_W'(i));
        assign q_next[i*LANE_W +: LANE_W] =
            (wr && sel[i]) ? wdata : q[i*LANE_W +: LANE_W];
    end

    assign wr_hit = wr && (sel != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < LANES; i++)
            if (sel[i]) rdata = rdata | q[i*LANE_W +: LANE_W];
    end

    // R2/R3: storage only moves on a write that addresses this bank
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(q));
endmodule

// File: rtl/gpob_notify.sv
module gpob_notify
    import gpob_pkg::*;
#(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [LINES-1:0] lvl_next,
    output logic [LINES-1:0] lvl_pub,
    output logic [LINES-1:0] chg_mask,
    output logic             chg_valid
);
    notify_state_t    state_q, state_d;
    logic [LINES-1:0] diff;

    assign diff = lvl_pub ^ lvl_next;

    always_comb begin
        state_d = ST_QUIET;
        unique case (state_q)
            ST_QUIET:  state_d = (upd && diff != '0) ? ST_NOTIFY : ST_QUIET;
            ST_NOTIFY: state_d = (upd && diff != '0) ? ST_NOTIFY : ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_pub  <= '0;
            chg_mask <= '0;
        end else if (upd) begin
            lvl_pub  <= lvl_next;
            chg_mask <= diff;
        end
    end

    assign chg_valid = (state_q == ST_NOTIFY);

    p_mask_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> chg_mask != '0);
    p_mask_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chg_valid |-> chg_mask == (lvl_pub ^ $past(lvl_pub)));
    p_no_strobe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> !chg_valid);
    p_level_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(lvl_pub));
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8,
    parameter int LANES  = 3,
    parameter int LINES  = 16,
    parameter logic [ADDR_W-1:0] DATA_BASE = 8'h78,
    parameter logic [ADDR_W-1:0] OE_BASE   = 8'h7C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LANE_W-1:0] reg_wdata,
    output logic [LANE_W-1:0] reg_rdata,
    output logic [LINES-1:0]  gpio_out,
    output logic [LINES-1:0]  chg_mask,
    output logic              chg_valid
);
    localparam int W = LANE_W * LANES;

    logic [W-1:0]      dat_q, dat_n, oe_q, oe_n;
    logic              dat_hit, oe_hit;
    logic [LANE_W-1:0] dat_rd, oe_rd;
    logic [LINES-1:0]  lvl_next;

    gpob_lanes #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES), .BASE(DATA_BASE)) u_data (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .q(dat_q), .q_next(dat_n), .wr_hit(dat_hit), .rdata(dat_rd));

    gpob_lanes #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES), .BASE(OE_BASE)) u_oe (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .q(oe_q), .q_next(oe_n), .wr_hit(oe_hit), .rdata(oe_rd));

    assign lvl_next  = dat_n[LINES-1:0] & oe_n[LINES-1:0];
    assign reg_rdata = dat_rd | oe_rd;

    gpob_notify #(.LINES(LINES)) u_notify (
        .clk(clk), .rst_n(rst_n), .upd(dat_hit | oe_hit), .lvl_next(lvl_next),
        .lvl_pub(gpio_out), .chg_mask(chg_mask), .chg_valid(chg_valid));

    // R4: published lines track the stored registers
    p_out_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_out == (dat_q[LINES-1:0] & oe_q[LINES-1:0]));
endmodule

// File: tb/tb_gpio_out_bank.sv
`timescale 1ns/1ps
module tb_gpio_out_bank;
    logic        clk = 0, rst_n = 0, reg_wr = 0;
    logic [7:0]  reg_addr = 0, reg_wdata = 0, reg_rdata;
    logic [15:0] gpio_out, chg_mask;
    logic        chg_valid;
    int checks = 0, errors = 0;
    bit done = 0;

    logic [23:0] m_dat = 0, m_oe = 0;
    logic [15:0] m_lvl = 0;
    logic [15:0] q_mask[$];
    logic [15:0] q_lvl[$];

    always #4 clk = ~clk;

    gpio_out_bank dut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_out(gpio_out),
        .chg_mask(chg_mask), .chg_valid(chg_valid));

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // driver: applies a write at a negedge, predicts any strobe
    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        logic [15:0] nl;
        reg_wr = 1; reg_addr = a; reg_wdata = v;
        if (a >= 8'h78 && a <= 8'h7A) m_dat[(a-8'h78)*8 +: 8] = v;
        if (a >= 8'h7C && a <= 8'h7E) m_oe[(a-8'h7C)*8 +: 8] = v;
        nl = m_dat[15:0] & m_oe[15:0];
        if (nl != m_lvl) begin
            q_mask.push_back(nl ^ m_lvl);
            q_lvl.push_back(nl);
        end
        m_lvl = nl;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        reg_wr = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a; #1;
        chk({24'd0, reg_rdata}, {24'd0, exp}, tag);
    endtask

    // monitor: every strobe must match the front of the queue
    always @(negedge clk) begin
        if (rst_n && chg_valid) begin
            if (q_mask.size() == 0) begin
                chk({16'd0, chg_mask}, 32'h0, "R6 unexpected strobe");
            end else begin
                chk({16'd0, chg_mask}, {16'd0, q_mask.pop_front()}, "R5 chg_mask");
                chk({16'd0, gpio_out}, {16'd0, q_lvl.pop_front()}, "R4 level at strobe");
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({31'd0, chg_valid}, 0, "R1 chg_valid reset");
        chk({16'd0, gpio_out}, 0, "R1 gpio_out reset");
        rst_n = 1;
        @(negedge clk);
        rd(8'h78, 8'h00, "R1 data lane0 reset");
        rd(8'h7E, 8'h00, "R1 oe lane2 reset");

        wr(8'h78, 8'hA5); idle(2);                       // R6: enable still zero
        rd(8'h78, 8'hA5, "R2 data lane0 readback");
        rd(8'h79, 8'h00, "R2 lane1 untouched");
        chk({16'd0, gpio_out}, 0, "R6 gated by enable");

        wr(8'h7C, 8'h0F); idle(2);                       // R3/R5 level 0x0005
        rd(8'h7C, 8'h0F, "R3 oe lane0 readback");
        chk({16'd0, gpio_out}, 32'h0005, "R4 masked output");

        wr(8'h78, 8'hFF); wr(8'h7C, 8'hF0); idle(2);     // R9 consecutive strobes
        chk({16'd0, gpio_out}, 32'h00F0, "R9 final level");

        wr(8'h79, 8'h3C); wr(8'h7D, 8'h0F); idle(2);     // lane1
        rd(8'h79, 8'h3C, "R2 data lane1 readback");
        chk({16'd0, gpio_out}, 32'h0CF0, "R4 lane1 output");

        wr(8'h7A, 8'hFF); wr(8'h7E, 8'hFF); idle(2);     // R7 upper lane
        rd(8'h7A, 8'hFF, "R7 data lane2 stored");
        rd(8'h7E, 8'hFF, "R7 oe lane2 stored");
        chk({16'd0, gpio_out}, 32'h0CF0, "R7 upper bits ignored");

        wr(8'h7B, 8'hFF); wr(8'h50, 8'h12); wr(8'h7F, 8'hFF); idle(2);  // R8
        rd(8'h7B, 8'h00, "R8 gap read");
        rd(8'h50, 8'h00, "R8 foreign read");
        rd(8'h78, 8'hFF, "R8 data lane0 kept");
        chk({16'd0, gpio_out}, 32'h0CF0, "R8 outputs kept");

        wr(8'h79, 8'h3C); idle(2);                       // R6 same value
        wr(8'h7D, 8'h00); idle(2);                       // clears lane1 lines
        chk({16'd0, gpio_out}, 32'h00F0, "R4 lane1 disabled");

        idle(3);
        chk(q_mask.size(), 0, "R5 all predicted strobes seen");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule